// File: doc/BRIEF.md
# SPI Word-Framing Master

This block is a serial peripheral master for the mode where the serial clock idles low and data is captured on the first (rising) clock edge. Words are loaded into a small transmit queue through a push port. Whenever the block is enabled and the queue holds a word, it drives the active-low frame select low and shifts the word out most significant bit first. At the same time it shifts in the slave's reply, which is presented right-aligned together with a one-cycle valid strobe.

Every word gets its own frame. After a word's last bit, frame select is released high, and it stays high for at least one serial-clock period before the next queued word starts. A slave that latches its shift register on the select edge therefore sees a separate frame for each word. The serial-clock half period is a whole number of system cycles, and the word length runs from 4 to 16 bits. Both settings are latched when a frame starts.

Top module: `spi_wordframe_master`

## Requirements
- R1: After reset, and whenever no frame is active, sclk is 0, sel_n is 1, mosi is 0 and rx_valid is 0. After reset the queue is empty, so queue_full is 0.
- R2: A frame starts only from idle, on a clock edge where enable is 1 and the queue holds a word. At that edge sel_n falls and the word leaves the queue. While enable is 0, queued words stay queued and no frame starts.
- R3: Let H be max(half_div, 1) system cycles. The word's MSB appears on mosi H cycles after sel_n falls, and the first sclk rise comes H cycles after that. Each sclk high or low phase lasts exactly H cycles. mosi moves to the next lower bit on each sclk fall and holds bit 0 after the last fall.
- R4: miso is sampled at the system clock edge that raises sclk. When the last bit is sampled, rx_valid is 1 for exactly that one cycle, and rx_data holds the received bits right-aligned (first bit received in bit N-1, zeros above).
- R5: sel_n returns high, and mosi returns to 0, 2H cycles after the last rising sclk edge of a word (one full serial-clock period).
- R6: With further words queued and enable held, sel_n stays high for exactly 2H+1 system cycles between consecutive frames. It is never held low across two words.
- R7: The word length N is word_len clamped to the range 4..16: values below 4 act as 4 and values above 16 act as 16. A frame gives exactly N sclk pulses. N and H are latched at frame start, so changes to word_len or half_div during a frame have no effect on that frame.
- R8: The queue holds 8 words. queue_full is 1 exactly when 8 words are held. A push on an edge where the queue already held 8 words is dropped.
- R9: Clearing enable during a frame lets that word finish normally. No further frame starts until enable is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new frames to start |
| half_div | input | 8 | Serial-clock half period in system cycles (0 acts as 1) |
| word_len | input | 5 | Bits per word, clamped to 4..16 |
| push_valid | input | 1 | Push a word into the transmit queue |
| push_data | input | 16 | Word to push; bits above the word length are ignored |
| queue_full | output | 1 | Transmit queue holds 8 words |
| sclk | output | 1 | Serial clock, idles low |
| sel_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| rx_valid | output | 1 | One-cycle strobe when a received word is complete |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
Single words at several lengths and dividers (8 bits at H=2, 16 bits at H=3, 4 bits at H=1) show whether the setup, lead and release delays scale with H and whether MSB-first ordering holds at the length extremes. A burst of three queued words at the minimum divider tells per-word framing apart from a select held low across words, and measures the exact high gap. Out-of-range lengths, a divider change mid-frame, an overfilled queue, and enable dropped mid-frame each test a case where the block must ignore something: clamping, latching, dropping pushes, and finishing the current word without starting another.

// File: rtl/spi_wf_pkg.sv
package spi_wf_pkg;

  // Frame sequencer phases; each non-idle phase lasts one half period
  typedef enum logic [2:0] {
    ST_IDLE,   // select high, waiting for enable and a queued word
    ST_SETUP,  // select low, data line still low
    ST_LEAD,   // first bit presented, clock still low
    ST_HIGH,   // clock high, bit captured at entry
    ST_LOW,    // clock low, next bit presented at entry
    ST_TAIL,   // last fall done, one more half period before release
    ST_GAP     // select high for two half periods
  } seq_state_t;

  localparam int MIN_BITS = 4;

endpackage

// File: rtl/spi_wf_txq.sv
module spi_wf_txq #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rd_data = mem[rd_ptr];

  // storage has no reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_wf_halftick.sv
module spi_wf_halftick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] half_cycles,
  output logic            tick
);
  logic [DIVW-1:0] cnt;
  logic [DIVW-1:0] last;

  assign last = half_cycles - DIVW'(1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIVW'(1);
  end
endmodule

// File: rtl/spi_wf_engine.sv
module spi_wf_engine
  import spi_wf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int DIVW = 8,
  parameter int LENW = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic [DIVW-1:0] half_div,
  input  logic [LENW-1:0] word_len,
  input  logic            q_empty,
  input  logic [DW-1:0]   q_data,
  output logic            q_pop,
  input  logic            tick,
  output logic            run,
  output logic [DIVW-1:0] half_q,
  output logic            sclk,
  output logic            sel_n,
  output logic            mosi,
  input  logic            miso,
  output logic            rx_valid,
  output logic [DW-1:0]   rx_data
);
  seq_state_t      state;
  logic [DW-1:0]   tx_sh, rx_sh;
  logic [LENW-1:0] len_q, len_c, bit_idx;
  logic            gap_half;
  logic            last_bit;
  logic [DW-1:0]   rx_next;

  assign len_c = (word_len < LENW'(MIN_BITS)) ? LENW'(MIN_BITS) :
                 (word_len > LENW'(DW))       ? LENW'(DW) : word_len;
  assign q_pop    = (state == ST_IDLE) && enable && !q_empty;
  assign run      = (state != ST_IDLE);
  assign last_bit = (bit_idx == len_q - LENW'(1));
  assign rx_next  = {rx_sh[DW-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tx_sh    <= '0;
      rx_sh    <= '0;
      len_q    <= LENW'(MIN_BITS);
      half_q   <= DIVW'(1);
      bit_idx  <= '0;
      gap_half <= 1'b0;
      sclk     <= 1'b0;
      sel_n    <= 1'b1;
      mosi     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (q_pop) begin
            tx_sh   <= q_data << (LENW'(DW) - len_c);
            rx_sh   <= '0;
            len_q   <= len_c;
            half_q  <= (half_div == '0) ? DIVW'(1) : half_div;
            bit_idx <= '0;
            sel_n   <= 1'b0;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            mosi  <= tx_sh[DW-1];
            state <= ST_LEAD;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (tick) begin
            sclk  <= 1'b1;
            rx_sh <= rx_next;
            if (last_bit) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_next;
            end
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (last_bit) begin
              state <= ST_TAIL;
            end else begin
              bit_idx <= bit_idx + LENW'(1);
              tx_sh   <= tx_sh << 1;
              mosi    <= tx_sh[DW-2];
              state   <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            sel_n    <= 1'b1;
            mosi     <= 1'b0;
            gap_half <= 1'b0;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) state <= ST_IDLE;
            else          gap_half <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_wordframe_master.sv
module spi_wordframe_master #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int DIVW  = 8,
  parameter int LENW  = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic [DIVW-1:0] half_div,
  input  logic [LENW-1:0] word_len,
  input  logic            push_valid,
  input  logic [DW-1:0]   push_data,
  output logic            queue_full,
  output logic            sclk,
  output logic            sel_n,
  output logic            mosi,
  input  logic            miso,
  output logic            rx_valid,
  output logic [DW-1:0]   rx_data
);
  logic            q_pop, q_empty, tick, run;
  logic [DW-1:0]   q_data;
  logic [DIVW-1:0] half_q;

  spi_wf_txq #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(push_valid), .push_data(push_data),
    .pop(q_pop), .rd_data(q_data), .empty(q_empty), .full(queue_full)
  );

  spi_wf_halftick #(.DIVW(DIVW)) u_tick (
    .clk(clk), .rst(rst), .run(run), .half_cycles(half_q), .tick(tick)
  );

  spi_wf_engine #(.DW(DW), .DIVW(DIVW), .LENW(LENW)) u_engine (
    .clk(clk), .rst(rst), .enable(enable), .half_div(half_div),
    .word_len(word_len), .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop),
    .tick(tick), .run(run), .half_q(half_q), .sclk(sclk), .sel_n(sel_n),
    .mosi(mosi), .miso(miso), .rx_valid(rx_valid), .rx_data(rx_data)
  );
endmodule

// File: rtl/spi_wf_checker.sv
module spi_wf_checker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic sclk,
  input logic sel_n,
  input logic mosi,
  input logic rx_valid,
  input logic queue_full,
  input logic push_valid,
  input logic pop
);
  // R1: no clock activity while deselected
  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> !sclk);

  // R2: a frame only opens after an enabled cycle
  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n) |-> $past(enable));

  // R4: receive strobe coincides with a rising serial clock
  assert_rx_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $rose(sclk));

  // R4: strobe lasts a single cycle
  assert_rx_single_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5: release happens with clock low and data line low
  assert_release_clean_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n) |-> (!sclk && !mosi));

  // R8: a full queue stays full when pushed and not popped
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (queue_full && push_valid && !pop) |=> queue_full);
endmodule

bind spi_wordframe_master spi_wf_checker u_chk (
  .clk(clk), .rst(rst), .enable(enable), .sclk(sclk), .sel_n(sel_n),
  .mosi(mosi), .rx_valid(rx_valid), .queue_full(queue_full),
  .push_valid(push_valid), .pop(q_pop)
);

// File: tb/spi_wordframe_master_bench.sv
module spi_wordframe_master_bench;
  localparam int DW = 16, DEPTH = 8, DIVW = 8, LENW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst = 1'b1, enable = 1'b0, push_valid = 1'b0, miso = 1'b0;
  logic [DIVW-1:0] half_div = 8'd1;
  logic [LENW-1:0] word_len = 5'd8;
  logic [DW-1:0]   push_data = '0;
  logic            queue_full, sclk, sel_n, mosi, rx_valid;
  logic [DW-1:0]   rx_data;

  spi_wordframe_master u_spi_wordframe_master (
    .clk(clk), .rst(rst), .enable(enable), .half_div(half_div),
    .word_len(word_len), .push_valid(push_valid), .push_data(push_data),
    .queue_full(queue_full), .sclk(sclk), .sel_n(sel_n), .mosi(mosi),
    .miso(miso), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mq[$];
  bit m_act = 0, accept;
  int m_e, m_len = 4, m_h = 1, m_word, m_sw;

  function automatic int clamp_len(input int l);
    return (l < 4) ? 4 : (l > 16) ? 16 : l;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_act = 0;
      m_e = 0;
    end else begin
      accept = (mq.size() < DEPTH);
      if (m_act) begin
        m_e++;
        if (m_e == (2 * m_len + 4) * m_h) m_act = 0;
      end else if (enable && mq.size() > 0) begin
        m_word = mq.pop_front();
        m_len  = clamp_len(int'(word_len));
        m_h    = (half_div == 0) ? 1 : int'(half_div);
        m_e    = 0;
        m_act  = 1;
        m_sw   = (m_word * 37 + 12345) & 16'hFFFF;
      end
      if (push_valid && accept) mq.push_back(int'(push_data));
    end
  end

  // ---------------- per-cycle comparison and slave ----------------
  int falls = 0, rises = 0, hi_run = 0, last_gap = 0;
  logic prev_sel = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    int p, j, e_sclk, e_sel, e_mosi, e_rxv, mask, k;
    if (!rst && !finished) begin
      e_sclk = 0; e_sel = 1; e_mosi = 0; e_rxv = 0; p = 0;
      mask = (1 << m_len) - 1;
      if (m_act) begin
        p = m_e / m_h;
        if (p <= 2 * m_len + 1) begin
          e_sel = 0;
          if (p >= 1) begin
            j = (p - 1) / 2;
            if (j > m_len - 1) j = m_len - 1;
            e_mosi = (m_word >> (m_len - 1 - j)) & 1;
          end
          e_sclk = (p >= 2 && p <= 2 * m_len && (p % 2) == 0) ? 1 : 0;
        end
        e_rxv = (m_e == 2 * m_len * m_h) ? 1 : 0;
      end
      check(sclk == e_sclk[0], "R3", "sclk", int'(sclk), e_sclk);
      check(sel_n == e_sel[0], "R5", "sel_n", int'(sel_n), e_sel);
      check(mosi == e_mosi[0], "R3", "mosi", int'(mosi), e_mosi);
      check(rx_valid == e_rxv[0], "R4", "rx_valid", int'(rx_valid), e_rxv);
      if (e_rxv == 1)
        check(int'(rx_data) == (m_sw & mask), "R4", "rx_data",
              int'(rx_data), m_sw & mask);
      check(queue_full == (mq.size() == DEPTH), "R8", "queue_full",
            int'(queue_full), int'(mq.size() == DEPTH));
      // slave: bit k is presented for the phase ending in the k-th rise
      if (m_act && p <= 2 * m_len + 1) begin
        k = (p <= 2) ? 0 : (p - 1) / 2;
        miso = (k <= m_len - 1) ? m_sw[m_len - 1 - k] : 1'b0;
      end else begin
        miso = 1'b0;
      end
      // edge and gap bookkeeping from the ports
      if (prev_sel && !sel_n) begin
        falls++;
        last_gap = hi_run;
      end
      if (!prev_sclk && sclk) rises++;
      hi_run = sel_n ? hi_run + 1 : 0;
      prev_sel = sel_n;
      prev_sclk = sclk;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic push_word(input int w);
    @(negedge clk);
    push_valid = 1'b1;
    push_data = DW'(w);
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic push_burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push_valid = 1'b1;
      push_data = DW'(base + i * 4099);
    end
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!m_act && !(enable && mq.size() > 0)) break;
    end
    repeat (3) @(negedge clk);
  endtask

  int f0, r0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sclk == 0, "R1", "reset sclk", int'(sclk), 0);
    check(sel_n == 1, "R1", "reset sel_n", int'(sel_n), 1);
    check(mosi == 0, "R1", "reset mosi", int'(mosi), 0);
    check(rx_valid == 0, "R1", "reset rx_valid", int'(rx_valid), 0);
    check(queue_full == 0, "R1", "reset queue_full", int'(queue_full), 0);

    // R2: disabled, a queued word must wait
    half_div = 8'd2; word_len = 5'd8;
    push_word(16'hA5);
    repeat (40) @(negedge clk);
    check(falls == 0, "R2", "frames while disabled", falls, 0);
    check(sel_n == 1, "R2", "sel_n while disabled", int'(sel_n), 1);
    enable = 1'b1;
    wait (sel_n == 1'b0);
    @(negedge clk);
    half_div = 8'd5;   // R7: mid-frame change must not apply
    word_len = 5'd12;
    wait_idle();
    check(falls == 1, "R2", "frames after enable", falls, 1);

    // R6: three queued words back to back at minimum divider
    half_div = 8'd1; word_len = 5'd12;
    enable = 1'b0;
    push_burst(3, 16'h0F3C);
    f0 = falls;
    enable = 1'b1;
    wait_idle();
    check(falls - f0 == 3, "R6", "frames in burst", falls - f0, 3);
    check(last_gap == 3, "R6", "select-high gap", last_gap, 3);

    // R7: length extremes and clamping
    half_div = 8'd3; word_len = 5'd16; r0 = rises;
    push_word(16'hC3A9); wait_idle();
    check(rises - r0 == 16, "R7", "pulses at 16", rises - r0, 16);
    half_div = 8'd1; word_len = 5'd4; r0 = rises;
    push_word(16'h0009); wait_idle();
    check(rises - r0 == 4, "R7", "pulses at 4", rises - r0, 4);
    word_len = 5'd20; r0 = rises;
    push_word(16'h8001); wait_idle();
    check(rises - r0 == 16, "R7", "clamp high", rises - r0, 16);
    word_len = 5'd2; half_div = 8'd0; r0 = rises;
    push_word(16'h000E); wait_idle();
    check(rises - r0 == 4, "R7", "clamp low", rises - r0, 4);

    // R8: overfill while disabled
    enable = 1'b0; half_div = 8'd1; word_len = 5'd6;
    push_burst(10, 16'h0123);
    @(negedge clk);
    check(queue_full == 1, "R8", "full after overfill", int'(queue_full), 1);
    f0 = falls;
    enable = 1'b1;
    wait_idle();
    check(falls - f0 == 8, "R8", "frames after overfill", falls - f0, 8);

    // R9: enable cleared during a frame
    enable = 1'b0; word_len = 5'd8; half_div = 8'd2;
    push_burst(2, 16'h5A5A);
    f0 = falls;
    enable = 1'b1;
    wait (sel_n == 1'b0);
    @(negedge clk);
    enable = 1'b0;
    repeat (200) @(negedge clk);
    check(falls - f0 == 1, "R9", "frames after disable", falls - f0, 1);
    check(sel_n == 1, "R9", "sel_n after disable", int'(sel_n), 1);
    enable = 1'b1;
    wait_idle();
    check(falls - f0 == 2, "R9", "held word sent later", falls - f0, 2);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule